// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in the same cycle that an instruction is presented, whether a control-register access or a trap-return instruction has to raise an illegal-instruction exception or a virtual-instruction exception. It is purely combinational. The caller supplies the current privilege mode, the 12-bit register address, whether the access writes, the kind of trap return (if any), the floating-point and vector enable state, and the gate bits held in machine-, supervisor- and hypervisor-level control registers. The register file itself lives elsewhere. Only its gate bits arrive here.

Internally a direct-access path runs four checks: a machine-level gate check, a supervisor-level gate check, a privilege matrix and a virtual-level gate check. A separate path checks the alias registers that reach an indirectly selected register, and a third path checks trap returns. A fixed-priority merge turns these into at most one asserted exception flag. Any direct-access finding outranks the alias check. The machine- and supervisor-level checks can only raise the illegal flag, so the illegal flag always beats the virtual flag among direct checks.

Top module: `csr_perm_check`

## Requirements
- R1: With `valid_i` low both exception outputs are 0, and at no time are `ex_ii_o` and `ex_vi_o` high together.
- R2: Mode code `priv_i` is 3'b011 machine, 3'b001 HS, 3'b000 HU, 3'b101 VS, 3'b100 VU. Register level is `csr_addr_i[9:8]` (00 user, 01 supervisor, 10 hypervisor/VS, 11 machine). Machine mode may access every level. HS gets illegal only on machine level. HU gets illegal on every level except user. VS gets illegal on machine level and virtual on hypervisor level. VU gets illegal on machine level and virtual on hypervisor and supervisor levels.
- R3: A write (`csr_wr_i`=1) to an address with bits [11:10]=11 raises illegal in every mode, machine included. A read of the same address is allowed.
- R4: Addresses 0x001–0x003 raise illegal while `fp_off_i`=1. Addresses 0x008, 0x009, 0x00A, 0x00F and 0xC20–0xC22 raise illegal while `vec_off_i`=1.
- R5: Below machine mode, reading counter 0xC00+n (n < NUM_CNT) with `m_cnt_en_i[n]`=0 raises illegal. Below machine mode, reading a custom register (0x5C0–0x5FF or 0x800–0x8FF) with `m_cust_en_i`=0 also raises illegal.
- R6: In HU mode, counter n with `s_cnt_en_i[n]`=0 raises illegal, and a custom user register (0x800–0x8FF) with `s_cust_en_i`=0 raises illegal. HS is not affected by these bits.
- R7: In VS or VU mode, the following raise virtual: counter n with `h_cnt_en_i[n]`=0; a custom register with `h_cust_en_i`=0; in VU only, counter n with `s_cnt_en_i[n]`=0 or a custom user register with `s_cust_en_i`=0; in VS only, address 0x180 with `vtvm_i`=1.
- R8: The direct checks are resolved in the order machine-level, supervisor-level, privilege matrix, virtual-level, and the first check that fires decides the result.
- R9: Alias addresses are 0x151, 0x251 and 0x351. For these, the following raise illegal: any mode below machine with `m_ind_en_i`=0, or `ind_sel_ok_i`=0. When neither applies, VS or VU with `h_ind_en_i`=0 raises virtual. This result is used only when no direct check fired.
- R10: `xret_i` is 00 none, 01 machine return, 10 supervisor return, 11 non-maskable return. Machine and non-maskable returns outside machine mode raise illegal. For supervisor return: HU raises illegal; VU raises virtual; HS with `tsr_i`=1 raises illegal; VS with `vtsr_i`=1 raises virtual; machine mode is always allowed.
- R11: With `xret_i` non-zero the result comes from the return check alone, and all register-access inputs are ignored. With `xret_i`=00 and `csr_acc_i`=0 no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Instruction present |
| xret_i | input | 2 | Trap-return kind (R10 encoding) |
| csr_acc_i | input | 1 | Instruction is a register access |
| csr_addr_i | input | 12 | Register address |
| csr_wr_i | input | 1 | Access writes the register |
| priv_i | input | 3 | Current mode (R2 encoding) |
| fp_off_i | input | 1 | Floating-point state disabled |
| vec_off_i | input | 1 | Vector state disabled |
| m_cnt_en_i | input | NUM_CNT | Machine counter-enable bits |
| s_cnt_en_i | input | NUM_CNT | Supervisor counter-enable bits |
| h_cnt_en_i | input | NUM_CNT | Hypervisor counter-enable bits |
| m_cust_en_i | input | 1 | Machine state-enable for custom registers |
| s_cust_en_i | input | 1 | Supervisor state-enable for custom registers |
| h_cust_en_i | input | 1 | Hypervisor state-enable for custom registers |
| m_ind_en_i | input | 1 | Machine state-enable for alias registers |
| h_ind_en_i | input | 1 | Hypervisor state-enable for alias registers |
| ind_sel_ok_i | input | 1 | Current alias selector names an implemented register |
| tsr_i | input | 1 | Trap supervisor return from HS |
| vtsr_i | input | 1 | Trap supervisor return from VS |
| vtvm_i | input | 1 | Trap translation-register access from VS |
| ex_ii_o | output | 1 | Illegal-instruction exception |
| ex_vi_o | output | 1 | Virtual-instruction exception |

## Verification
The assertions assume that every input is at a known level and that `priv_i` carries one of the five defined mode codes. They skip evaluation whenever an input is unknown or the mode code is unused. The bench drives only the five legal codes. It sets every input to a defined value before it releases reset, and it changes inputs only on the falling clock edge. Because of this, the checker only ever sees settled, legal combinations.

// File: rtl/csr_perm_pkg.sv
`timescale 1ns/1ps
package csr_perm_pkg;

  typedef struct packed {
    logic ii;
    logic vi;
  } exc_t;

  typedef enum logic [1:0] {
    XR_NONE  = 2'b00,
    XR_MRET  = 2'b01,
    XR_SRET  = 2'b10,
    XR_MNRET = 2'b11
  } xret_e;

  typedef enum logic [1:0] {
    LVL_U = 2'b00,
    LVL_S = 2'b01,
    LVL_H = 2'b10,
    LVL_M = 2'b11
  } csr_lvl_e;

  localparam logic [2:0] MODE_HU = 3'b000;
  localparam logic [2:0] MODE_HS = 3'b001;
  localparam logic [2:0] MODE_M  = 3'b011;
  localparam logic [2:0] MODE_VU = 3'b100;
  localparam logic [2:0] MODE_VS = 3'b101;

  localparam logic [11:0] ADDR_SATP   = 12'h180;
  localparam logic [11:0] ADDR_MALIAS = 12'h351;
  localparam logic [11:0] ADDR_SALIAS = 12'h151;
  localparam logic [11:0] ADDR_VALIAS = 12'h251;

  function automatic logic mode_legal(input logic [2:0] m);
    return (m == MODE_HU) || (m == MODE_HS) || (m == MODE_M) ||
           (m == MODE_VU) || (m == MODE_VS);
  endfunction

  function automatic logic is_ro(input logic [11:0] a);
    return a[11:10] == 2'b11;
  endfunction

  function automatic logic is_fp(input logic [11:0] a);
    return (a == 12'h001) || (a == 12'h002) || (a == 12'h003);
  endfunction

  function automatic logic is_vec(input logic [11:0] a);
    return (a == 12'h008) || (a == 12'h009) || (a == 12'h00A) ||
           (a == 12'h00F) || (a == 12'hC20) || (a == 12'hC21) ||
           (a == 12'hC22);
  endfunction

  function automatic logic is_cust_s(input logic [11:0] a);
    return a[11:6] == 6'b010111;
  endfunction

  function automatic logic is_cust_u(input logic [11:0] a);
    return a[11:8] == 4'h8;
  endfunction

  function automatic logic is_alias(input logic [11:0] a);
    return (a == ADDR_MALIAS) || (a == ADDR_SALIAS) || (a == ADDR_VALIAS);
  endfunction

  // Mode against register level.
  function automatic exc_t priv_matrix(input logic [2:0] m, input logic [11:0] a);
    exc_t     r;
    csr_lvl_e lvl;
    lvl = csr_lvl_e'(a[9:8]);
    r   = '0;
    unique case (m)
      MODE_M:  r = '0;
      MODE_HS: r.ii = (lvl == LVL_M);
      MODE_VS: begin
        r.ii = (lvl == LVL_M);
        r.vi = (lvl == LVL_H);
      end
      MODE_VU: begin
        r.ii = (lvl == LVL_M);
        r.vi = (lvl == LVL_H) || (lvl == LVL_S);
      end
      default: r.ii = (lvl != LVL_U);
    endcase
    return r;
  endfunction

  // Trap-return legality.
  function automatic exc_t xret_check(input logic [1:0] x, input logic [2:0] m,
                                      input logic tsr, input logic vtsr);
    exc_t r;
    r = '0;
    unique case (xret_e'(x))
      XR_MRET, XR_MNRET: r.ii = (m != MODE_M);
      XR_SRET: begin
        if (m == MODE_HU)      r.ii = 1'b1;
        else if (m == MODE_VU) r.vi = 1'b1;
        else if (m == MODE_HS) r.ii = tsr;
        else if (m == MODE_VS) r.vi = vtsr;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/csr_perm_direct.sv
`timescale 1ns/1ps
module csr_perm_direct
  import csr_perm_pkg::*;
#(
  parameter int          NUM_CNT  = 32,
  parameter logic [11:0] CNT_BASE = 12'hC00
) (
  input  logic [2:0]         mode_i,
  input  logic [11:0]        addr_i,
  input  logic               wr_i,
  input  logic               fp_off_i,
  input  logic               vec_off_i,
  input  logic [NUM_CNT-1:0] m_cnt_en_i,
  input  logic [NUM_CNT-1:0] s_cnt_en_i,
  input  logic [NUM_CNT-1:0] h_cnt_en_i,
  input  logic               m_cust_en_i,
  input  logic               s_cust_en_i,
  input  logic               h_cust_en_i,
  input  logic               vtvm_i,
  output logic               m_ii_o,
  output logic               s_ii_o,
  output exc_t               pr_o,
  output logic               v_vi_o
);
  localparam int CNT_IW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic [12:0]       cnt_off;
  logic              cnt_hit;
  logic [CNT_IW-1:0] cnt_idx;
  logic              m_bit, s_bit, h_bit;
  logic              below_m, virt, cust_any;

  assign cnt_off  = {1'b0, addr_i} - {1'b0, CNT_BASE};
  assign cnt_hit  = !cnt_off[12] && (cnt_off < 13'(NUM_CNT));
  assign cnt_idx  = cnt_off[CNT_IW-1:0];
  assign m_bit    = m_cnt_en_i[cnt_idx];
  assign s_bit    = s_cnt_en_i[cnt_idx];
  assign h_bit    = h_cnt_en_i[cnt_idx];
  assign below_m  = (mode_i != MODE_M);
  assign virt     = mode_i[2];
  assign cust_any = is_cust_s(addr_i) || is_cust_u(addr_i);

  always_comb begin
    m_ii_o = (wr_i && is_ro(addr_i))
          || (fp_off_i && is_fp(addr_i))
          || (vec_off_i && is_vec(addr_i))
          || (below_m && cnt_hit && !m_bit)
          || (below_m && cust_any && !m_cust_en_i);
  end

  always_comb begin
    s_ii_o = (mode_i == MODE_HU) &&
             ((cnt_hit && !s_bit) || (is_cust_u(addr_i) && !s_cust_en_i));
  end

  assign pr_o = priv_matrix(mode_i, addr_i);

  always_comb begin
    v_vi_o = virt && ((cnt_hit && !h_bit)
                   || (cust_any && !h_cust_en_i)
                   || ((mode_i == MODE_VU) && cnt_hit && !s_bit)
                   || ((mode_i == MODE_VU) && is_cust_u(addr_i) && !s_cust_en_i)
                   || ((mode_i == MODE_VS) && (addr_i == ADDR_SATP) && vtvm_i));
  end
endmodule

// File: rtl/csr_perm_alias.sv
`timescale 1ns/1ps
module csr_perm_alias
  import csr_perm_pkg::*;
(
  input  logic [2:0]  mode_i,
  input  logic [11:0] addr_i,
  input  logic        m_ind_en_i,
  input  logic        h_ind_en_i,
  input  logic        sel_ok_i,
  output exc_t        res_o
);
  logic hit;
  assign hit = is_alias(addr_i);

  always_comb begin
    res_o    = '0;
    res_o.ii = hit && (((mode_i != MODE_M) && !m_ind_en_i) || !sel_ok_i);
    res_o.vi = hit && !res_o.ii && mode_i[2] && !h_ind_en_i;
  end
endmodule

// File: rtl/csr_perm_xret.sv
`timescale 1ns/1ps
module csr_perm_xret
  import csr_perm_pkg::*;
(
  input  logic [1:0] xret_i,
  input  logic [2:0] mode_i,
  input  logic       tsr_i,
  input  logic       vtsr_i,
  output exc_t       res_o
);
  assign res_o = xret_check(xret_i, mode_i, tsr_i, vtsr_i);
endmodule

// File: rtl/csr_perm_check.sv
`timescale 1ns/1ps
module csr_perm_check
  import csr_perm_pkg::*;
#(
  parameter int          NUM_CNT   = 32,
  parameter logic [11:0] CNT_BASE  = 12'hC00,
  parameter bit          HAS_ALIAS = 1'b1
) (
  input  logic               valid_i,
  input  logic [1:0]         xret_i,
  input  logic               csr_acc_i,
  input  logic [11:0]        csr_addr_i,
  input  logic               csr_wr_i,
  input  logic [2:0]         priv_i,
  input  logic               fp_off_i,
  input  logic               vec_off_i,
  input  logic [NUM_CNT-1:0] m_cnt_en_i,
  input  logic [NUM_CNT-1:0] s_cnt_en_i,
  input  logic [NUM_CNT-1:0] h_cnt_en_i,
  input  logic               m_cust_en_i,
  input  logic               s_cust_en_i,
  input  logic               h_cust_en_i,
  input  logic               m_ind_en_i,
  input  logic               h_ind_en_i,
  input  logic               ind_sel_ok_i,
  input  logic               tsr_i,
  input  logic               vtsr_i,
  input  logic               vtvm_i,
  output logic               ex_ii_o,
  output logic               ex_vi_o
);
  // Named sub-results for the checker.
  logic m_ii, s_ii, v_vi;
  exc_t pr_res, ind_res, x_res, merged;
  logic direct_hit, xret_path, csr_path;

  csr_perm_direct #(.NUM_CNT(NUM_CNT), .CNT_BASE(CNT_BASE)) u_direct (
    .mode_i      (priv_i),
    .addr_i      (csr_addr_i),
    .wr_i        (csr_wr_i),
    .fp_off_i    (fp_off_i),
    .vec_off_i   (vec_off_i),
    .m_cnt_en_i  (m_cnt_en_i),
    .s_cnt_en_i  (s_cnt_en_i),
    .h_cnt_en_i  (h_cnt_en_i),
    .m_cust_en_i (m_cust_en_i),
    .s_cust_en_i (s_cust_en_i),
    .h_cust_en_i (h_cust_en_i),
    .vtvm_i      (vtvm_i),
    .m_ii_o      (m_ii),
    .s_ii_o      (s_ii),
    .pr_o        (pr_res),
    .v_vi_o      (v_vi)
  );

  generate
    if (HAS_ALIAS) begin : g_alias
      csr_perm_alias u_alias (
        .mode_i     (priv_i),
        .addr_i     (csr_addr_i),
        .m_ind_en_i (m_ind_en_i),
        .h_ind_en_i (h_ind_en_i),
        .sel_ok_i   (ind_sel_ok_i),
        .res_o      (ind_res)
      );
    end else begin : g_no_alias
      assign ind_res = '0;
    end
  endgenerate

  csr_perm_xret u_xret (
    .xret_i (xret_i),
    .mode_i (priv_i),
    .tsr_i  (tsr_i),
    .vtsr_i (vtsr_i),
    .res_o  (x_res)
  );

  assign direct_hit = m_ii || s_ii || pr_res.ii || pr_res.vi || v_vi;
  assign xret_path  = valid_i && (xret_i != XR_NONE);
  assign csr_path   = valid_i && (xret_i == XR_NONE) && csr_acc_i;

  always_comb begin
    merged = '0;
    if (xret_path) begin
      merged = x_res;
    end else if (csr_path) begin
      if (m_ii)                         merged.ii = 1'b1;
      else if (s_ii)                    merged.ii = 1'b1;
      else if (pr_res.ii || pr_res.vi)  merged    = pr_res.ii ? 2'b10 : 2'b01;
      else if (v_vi)                    merged.vi = 1'b1;
      else if (ind_res.ii)              merged.ii = 1'b1;
      else if (ind_res.vi)              merged.vi = 1'b1;
    end
  end

  assign ex_ii_o = merged.ii;
  assign ex_vi_o = merged.vi;
endmodule

// File: rtl/csr_perm_check_sva.sv
`timescale 1ns/1ps
module csr_perm_check_sva
  import csr_perm_pkg::*;
(
  input logic        valid_i,
  input logic [1:0]  xret_i,
  input logic        csr_acc_i,
  input logic [11:0] csr_addr_i,
  input logic        csr_wr_i,
  input logic [2:0]  priv_i,
  input logic        m_ii,
  input logic        direct_hit,
  input logic        ind_ii,
  input logic        ind_vi,
  input logic        x_ii,
  input logic        x_vi,
  input logic        ex_ii_o,
  input logic        ex_vi_o
);
  logic known;
  logic csr_path;
  assign known = !$isunknown({valid_i, xret_i, csr_acc_i, csr_addr_i, csr_wr_i,
                              priv_i, m_ii, direct_hit, ind_ii, ind_vi, x_ii, x_vi,
                              ex_ii_o, ex_vi_o}) && mode_legal(priv_i);
  assign csr_path = valid_i && (xret_i == 2'b00) && csr_acc_i;

  always_comb begin
    if (known) begin
      // R1
      idle_quiet_chk: assert (valid_i || (!ex_ii_o && !ex_vi_o))
        else $error("exception raised without a valid instruction");
      // R1
      single_exc_chk: assert ($onehot0({ex_ii_o, ex_vi_o}))
        else $error("both exception flags high");
      // R2
      mmode_no_vi_chk: assert (!(valid_i && priv_i == MODE_M) || !ex_vi_o)
        else $error("virtual exception raised in machine mode");
      // R3
      ro_write_chk: assert (!(csr_path && csr_wr_i && csr_addr_i[11:10] == 2'b11) || ex_ii_o)
        else $error("write to read-only address not trapped");
      // R8
      mlevel_first_chk: assert (!(csr_path && m_ii) || (ex_ii_o && !ex_vi_o))
        else $error("machine-level finding lost in merge");
      // R9
      direct_wins_chk: assert (!(csr_path && direct_hit) || (ex_ii_o || ex_vi_o))
        else $error("direct finding not reported");
      // R9
      alias_used_chk: assert (!(csr_path && !direct_hit && ind_ii) || ex_ii_o)
        else $error("alias illegal finding not reported");
      // R11
      xret_excl_chk: assert (!(valid_i && xret_i != 2'b00) ||
                             (ex_ii_o == x_ii && ex_vi_o == x_vi))
        else $error("return result disturbed by access path");
      // R11
      no_op_quiet_chk: assert (!(valid_i && xret_i == 2'b00 && !csr_acc_i) ||
                               (!ex_ii_o && !ex_vi_o))
        else $error("exception with neither access nor return");
      // R10
      mret_low_chk: assert (!(valid_i && xret_i == 2'b01 && priv_i != MODE_M) || ex_ii_o)
        else $error("machine return below machine mode not trapped");
    end
  end
endmodule

bind csr_perm_check csr_perm_check_sva u_sva (
  .valid_i    (valid_i),
  .xret_i     (xret_i),
  .csr_acc_i  (csr_acc_i),
  .csr_addr_i (csr_addr_i),
  .csr_wr_i   (csr_wr_i),
  .priv_i     (priv_i),
  .m_ii       (m_ii),
  .direct_hit (direct_hit),
  .ind_ii     (ind_res.ii),
  .ind_vi     (ind_res.vi),
  .x_ii       (x_res.ii),
  .x_vi       (x_res.vi),
  .ex_ii_o    (ex_ii_o),
  .ex_vi_o    (ex_vi_o)
);

// File: tb/csr_perm_check_bench.sv
`timescale 1ns/1ps
module csr_perm_check_bench;
  localparam int NCNT = 32;
  localparam logic [2:0] HU = 3'b000, HS = 3'b001, MM = 3'b011, VU = 3'b100, VS = 3'b101;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic            valid_i, csr_acc_i, csr_wr_i, fp_off_i, vec_off_i;
  logic [1:0]      xret_i;
  logic [11:0]     csr_addr_i;
  logic [2:0]      priv_i;
  logic [NCNT-1:0] m_cnt_en_i, s_cnt_en_i, h_cnt_en_i;
  logic            m_cust_en_i, s_cust_en_i, h_cust_en_i;
  logic            m_ind_en_i, h_ind_en_i, ind_sel_ok_i;
  logic            tsr_i, vtsr_i, vtvm_i;
  logic            ex_ii_o, ex_vi_o;

  int checks = 0;
  int fails  = 0;

  csr_perm_check u_csr_perm_check (
    .valid_i(valid_i), .xret_i(xret_i), .csr_acc_i(csr_acc_i),
    .csr_addr_i(csr_addr_i), .csr_wr_i(csr_wr_i), .priv_i(priv_i),
    .fp_off_i(fp_off_i), .vec_off_i(vec_off_i),
    .m_cnt_en_i(m_cnt_en_i), .s_cnt_en_i(s_cnt_en_i), .h_cnt_en_i(h_cnt_en_i),
    .m_cust_en_i(m_cust_en_i), .s_cust_en_i(s_cust_en_i), .h_cust_en_i(h_cust_en_i),
    .m_ind_en_i(m_ind_en_i), .h_ind_en_i(h_ind_en_i), .ind_sel_ok_i(ind_sel_ok_i),
    .tsr_i(tsr_i), .vtsr_i(vtsr_i), .vtvm_i(vtvm_i),
    .ex_ii_o(ex_ii_o), .ex_vi_o(ex_vi_o)
  );

  task automatic defaults();
    valid_i = 1'b1; xret_i = 2'b00; csr_acc_i = 1'b1; csr_wr_i = 1'b0;
    csr_addr_i = 12'h340; priv_i = MM; fp_off_i = 1'b0; vec_off_i = 1'b0;
    m_cnt_en_i = '1; s_cnt_en_i = '1; h_cnt_en_i = '1;
    m_cust_en_i = 1'b1; s_cust_en_i = 1'b1; h_cust_en_i = 1'b1;
    m_ind_en_i = 1'b1; h_ind_en_i = 1'b1; ind_sel_ok_i = 1'b1;
    tsr_i = 1'b0; vtsr_i = 1'b0; vtvm_i = 1'b0;
  endtask

  task automatic access(input logic [2:0] m, input logic [11:0] a, input logic wr);
    priv_i = m; csr_addr_i = a; csr_wr_i = wr;
  endtask

  // Inputs are set just after a falling edge; outputs are read 1 ns later.
  task automatic expect_exc(input string tag, input logic e_ii, input logic e_vi);
    #1;
    checks++;
    if (ex_ii_o !== e_ii || ex_vi_o !== e_vi) begin
      fails++;
      $display("FAIL %s: got ii=%b vi=%b, expected ii=%b vi=%b",
               tag, ex_ii_o, ex_vi_o, e_ii, e_vi);
    end
    @(negedge clk);
  endtask

  function automatic logic [1:0] matrix_exp(input logic [2:0] m, input logic [1:0] lvl);
    if (lvl == 2'b00 || m == MM) return 2'b00;
    if (lvl == 2'b11)            return 2'b10;
    if (m == HS)                 return 2'b00;
    if (m == HU)                 return 2'b10;
    if (lvl == 2'b10)            return 2'b01;
    if (m == VU)                 return 2'b01;
    return 2'b00;
  endfunction

  task automatic t_idle();
    defaults(); valid_i = 1'b0; access(HU, 12'hF11, 1'b1);
    expect_exc("R1 invalid ro write", 1'b0, 1'b0);
    xret_i = 2'b10; expect_exc("R1 invalid return", 1'b0, 1'b0);
  endtask

  task automatic t_matrix();
    logic [2:0]  modes [5];
    logic [11:0] addrs [4];
    logic [1:0]  e;
    modes = '{HU, HS, MM, VU, VS};
    addrs = '{12'h015, 12'h140, 12'h240, 12'h340};
    defaults();
    foreach (modes[i]) begin
      for (int l = 0; l < 4; l++) begin
        access(modes[i], addrs[l], 1'b0);
        e = matrix_exp(modes[i], 2'(l));
        expect_exc($sformatf("R2 mode=%b lvl=%0d", modes[i], l), e[1], e[0]);
      end
    end
  endtask

  task automatic t_ro();
    defaults();
    access(MM, 12'hF11, 1'b1); expect_exc("R3 M write ro", 1'b1, 1'b0);
    access(MM, 12'hF11, 1'b0); expect_exc("R3 M read ro", 1'b0, 1'b0);
    access(VS, 12'hC01, 1'b1); expect_exc("R3 VS write counter", 1'b1, 1'b0);
  endtask

  task automatic t_fpvec();
    defaults(); fp_off_i = 1'b1;
    access(MM, 12'h002, 1'b0); expect_exc("R4 fp off", 1'b1, 1'b0);
    fp_off_i = 1'b0; expect_exc("R4 fp on", 1'b0, 1'b0);
    vec_off_i = 1'b1; access(MM, 12'h008, 1'b0); expect_exc("R4 vec off", 1'b1, 1'b0);
    access(HU, 12'hC21, 1'b0); expect_exc("R4 vec off 0xC21", 1'b1, 1'b0);
    vec_off_i = 1'b0; expect_exc("R4 vec on 0xC21", 1'b0, 1'b0);
  endtask

  task automatic t_mgate();
    defaults(); m_cnt_en_i[5] = 1'b0;
    access(HS, 12'hC05, 1'b0); expect_exc("R5 HS counter gated", 1'b1, 1'b0);
    access(HS, 12'hC04, 1'b0); expect_exc("R5 HS other counter", 1'b0, 1'b0);
    access(MM, 12'hC05, 1'b0); expect_exc("R5 M ignores gate", 1'b0, 1'b0);
    defaults(); m_cust_en_i = 1'b0;
    access(HS, 12'h5C2, 1'b0); expect_exc("R5 HS custom gated", 1'b1, 1'b0);
  endtask

  task automatic t_sgate();
    defaults(); s_cnt_en_i[3] = 1'b0;
    access(HU, 12'hC03, 1'b0); expect_exc("R6 HU counter gated", 1'b1, 1'b0);
    access(HS, 12'hC03, 1'b0); expect_exc("R6 HS unaffected", 1'b0, 1'b0);
    defaults(); s_cust_en_i = 1'b0;
    access(HU, 12'h810, 1'b0); expect_exc("R6 HU custom gated", 1'b1, 1'b0);
  endtask

  task automatic t_vgate();
    defaults(); h_cnt_en_i[2] = 1'b0;
    access(VU, 12'hC02, 1'b0); expect_exc("R7 VU h counter", 1'b0, 1'b1);
    defaults(); s_cnt_en_i[2] = 1'b0;
    access(VU, 12'hC02, 1'b0); expect_exc("R7 VU s counter", 1'b0, 1'b1);
    access(VS, 12'hC02, 1'b0); expect_exc("R7 VS s counter ignored", 1'b0, 1'b0);
    defaults(); h_cust_en_i = 1'b0;
    access(VS, 12'h5C0, 1'b0); expect_exc("R7 VS custom", 1'b0, 1'b1);
    defaults(); vtvm_i = 1'b1;
    access(VS, 12'h180, 1'b0); expect_exc("R7 VS satp trapped", 1'b0, 1'b1);
    access(HS, 12'h180, 1'b0); expect_exc("R7 HS satp free", 1'b0, 1'b0);
  endtask

  task automatic t_prio();
    defaults(); m_cnt_en_i[2] = 1'b0; h_cnt_en_i[2] = 1'b0;
    access(VU, 12'hC02, 1'b0); expect_exc("R8 m gate over virt", 1'b1, 1'b0);
    defaults(); m_cust_en_i = 1'b0;
    access(VU, 12'h5C0, 1'b0); expect_exc("R8 m gate over matrix", 1'b1, 1'b0);
    defaults(); h_cust_en_i = 1'b0;
    access(VU, 12'h5C0, 1'b0); expect_exc("R8 matrix vi", 1'b0, 1'b1);
  endtask

  task automatic t_alias();
    defaults(); m_ind_en_i = 1'b0;
    access(HS, 12'h151, 1'b0); expect_exc("R9 HS m ind gate", 1'b1, 1'b0);
    access(MM, 12'h351, 1'b0); expect_exc("R9 M ignores ind gate", 1'b0, 1'b0);
    defaults(); ind_sel_ok_i = 1'b0;
    access(HS, 12'h151, 1'b0); expect_exc("R9 bad selector", 1'b1, 1'b0);
    defaults(); h_ind_en_i = 1'b0;
    access(VS, 12'h151, 1'b0); expect_exc("R9 VS h ind gate", 1'b0, 1'b1);
    ind_sel_ok_i = 1'b0; expect_exc("R9 ii over vi", 1'b1, 1'b0);
    defaults(); ind_sel_ok_i = 1'b0;
    access(VS, 12'h251, 1'b0); expect_exc("R9 direct outranks alias", 1'b0, 1'b1);
  endtask

  task automatic t_xret();
    defaults(); csr_acc_i = 1'b0;
    xret_i = 2'b01; priv_i = HS; expect_exc("R10 mret HS", 1'b1, 1'b0);
    priv_i = MM; expect_exc("R10 mret M", 1'b0, 1'b0);
    xret_i = 2'b11; priv_i = VS; expect_exc("R10 mnret VS", 1'b1, 1'b0);
    xret_i = 2'b10; priv_i = HU; expect_exc("R10 sret HU", 1'b1, 1'b0);
    priv_i = VU; expect_exc("R10 sret VU", 1'b0, 1'b1);
    priv_i = HS; expect_exc("R10 sret HS", 1'b0, 1'b0);
    tsr_i = 1'b1; expect_exc("R10 sret HS tsr", 1'b1, 1'b0);
    priv_i = MM; expect_exc("R10 sret M tsr", 1'b0, 1'b0);
    priv_i = VS; expect_exc("R10 sret VS", 1'b0, 1'b0);
    vtsr_i = 1'b1; expect_exc("R10 sret VS vtsr", 1'b0, 1'b1);
  endtask

  task automatic t_excl();
    defaults(); xret_i = 2'b10; access(MM, 12'hF11, 1'b1);
    expect_exc("R11 return hides ro write", 1'b0, 1'b0);
    defaults(); xret_i = 2'b01; access(HS, 12'h240, 1'b0); priv_i = VS;
    expect_exc("R11 return result only", 1'b1, 1'b0);
    defaults(); csr_acc_i = 1'b0; access(HU, 12'hF11, 1'b1);
    expect_exc("R11 no access no return", 1'b0, 1'b0);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    defaults(); valid_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_exc("R1 reset quiet", 1'b0, 1'b0);
    rst_n = 1'b1;
    t_idle(); t_matrix(); t_ro(); t_fpvec(); t_mgate(); t_sgate();
    t_vgate(); t_prio(); t_alias(); t_xret(); t_excl();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule